// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Modulator

This block generates two independent pulse-width modulated outputs from one input clock. Each channel slows the clock through a selectable prescaler, counts ticks over a programmable cycle, and drives its output at a chosen active level for a programmable number of ticks at the start of each cycle. Software programs the block through a small synchronous register port. One shared control word holds a field group for each channel. Each channel also has its own period/duty word.

A new period/duty value is held in a shadow copy. It moves into the running counter only when the current cycle ends, so the output never shows a cut-short or stretched cycle. A per-channel ready flag in the control word stays set while such an update is waiting. A channel that is stopped takes a new value on the next clock. The mode, pulse and bypass bits of each group are stored and read back, but they do not change the output.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: After reset, the control word and both period/duty words read 0, both ready flags read 0, and both outputs are high (active-state bit 0 makes the idle level high).
- R2: Word addresses are 0x0 for control, 0x4 for the channel 0 period/duty word and 0x8 for the channel 1 period/duty word; other addresses read 0. Channel n's group starts at control bit 15*n: bits 3:0 select the prescaler, bit 4 enables, bit 5 sets the active state, bit 6 gates the clock, and bits 7, 8 and 9 are mode, pulse and bypass, which are stored with no effect on the output. Ready flags at bits 28+n are read-only, and all other control bits read 0.
- R3: The period/duty word holds the cycle length minus one in bits 31:16 and the active tick count in bits 15:0. A cycle lasts (field+1) prescaled ticks, and the output is at its active level while the tick count within the cycle is below the duty count.
- R4: Prescaler codes 0-4 divide the clock by 120, 180, 240, 360 and 480, and codes 8-12 divide it by 12000, 24000, 36000, 48000 and 72000. Code 15 gives one tick per clock. Codes 5-7, 13 and 14 give no ticks, so the cycle counter holds.
- R5: With active state 1 the output is high during the duty part of the cycle; with active state 0 it is low during the duty part and high otherwise.
- R6: A channel runs only while both its enable bit and its clock-gate bit are 1. Otherwise it drives the inactive level and clears its cycle and prescale counters, so a restart begins a fresh cycle at tick 0.
- R7: A period/duty write to a running channel takes effect at the clock edge that ends the current cycle. The channel's ready flag is 1 from the write until that edge. On a stopped channel the write takes effect, and the flag clears, at the next clock edge.
- R8: A duty count of 0 keeps the output inactive for the whole cycle, and a duty count above the period field keeps it active for the whole cycle.
- R9: Programming or running one channel does not disturb the other channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 4 | Byte address of the word (bits 1:0 ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 2 | Channel outputs, bit n for channel n |

## Verification
The assertions check, on every cycle, that each cycle counter stays within its period, that the running period/duty values change only after an update was pending, that a ready flag rises only after a write, that stopped channels clear their counters and drive the inactive level, and that a zero duty count keeps the output inactive. Only the bench scenarios can show the waveform shapes themselves. These are the exact cycle at which a pending update lands, each divider ratio in both prescaler banks, the restart phase after gating, the stall on an unused code, readback masking, and the independence of the two channels.

// File: rtl/pwm_dual_pkg.sv
`timescale 1ns/1ps
package pwm_dual_pkg;

   localparam int unsigned DIV_W = 17;

   // field order follows bit positions inside one channel group (msb first)
   typedef struct packed {
      logic       bypass_b;
      logic       pulse_b;
      logic       mode_b;
      logic       gate;
      logic       act_hi;
      logic       en;
      logic [3:0] code;
   } chan_cfg_t;

   localparam int unsigned CFG_W = $bits(chan_cfg_t);

   // clock cycles per prescaled tick; 0 marks a code that yields no ticks
   function automatic logic [DIV_W-1:0] div_of_code(input logic [3:0] code);
      logic [DIV_W-1:0] d;
      case (code)
         4'd0:    d = DIV_W'(120);
         4'd1:    d = DIV_W'(180);
         4'd2:    d = DIV_W'(240);
         4'd3:    d = DIV_W'(360);
         4'd4:    d = DIV_W'(480);
         4'd8:    d = DIV_W'(12000);
         4'd9:    d = DIV_W'(24000);
         4'd10:   d = DIV_W'(36000);
         4'd11:   d = DIV_W'(48000);
         4'd12:   d = DIV_W'(72000);
         default: d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
`timescale 1ns/1ps
module pwm_tick_gen #(
   parameter int unsigned DIV_W   = 17,
   parameter bit          PASS_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [3:0] code,
   output logic       tick
);
   logic [DIV_W-1:0] div;
   logic [DIV_W-1:0] pcnt;
   logic             div_hit;

   assign div     = DIV_W'(pwm_dual_pkg::div_of_code(code));
   assign div_hit = run && (div != '0) && (pcnt >= div - 1'b1);

   generate
      if (PASS_EN) begin : g_pass
         assign tick = div_hit || (run && (code == 4'hF));
      end else begin : g_nopass
         assign tick = div_hit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt <= '0;
      else if (!run || (div == '0) || div_hit)
         pcnt <= '0;
      else
         pcnt <= pcnt + 1'b1;
   end

   // R6: a stopped channel restarts its prescaler from zero
   a_r6_prescale_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> pcnt == '0);

   // R4: unused codes never produce a tick
   a_r4_unused_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (div == '0) && (code != 4'hF)) |-> !tick);

endmodule

// File: rtl/pwm_chan_core.sv
`timescale 1ns/1ps
module pwm_chan_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic               act_hi,
   input  logic               wr,
   input  logic [CNT_W-1:0]   wr_prd,
   input  logic [CNT_W-1:0]   wr_dty,
   output logic               pwm_o,
   output logic               busy_o,
   output logic [2*CNT_W-1:0] shadow_o
);
   logic [CNT_W-1:0] sh_prd, sh_dty;
   logic [CNT_W-1:0] cur_prd, cur_dty;
   logic [CNT_W-1:0] cnt;
   logic             pend;
   logic             wrap;
   logic             load;

   assign wrap = run && tick && (cnt == cur_prd);
   assign load = pend && (!run || wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_prd  <= '0;
         sh_dty  <= '0;
         cur_prd <= '0;
         cur_dty <= '0;
         cnt     <= '0;
         pend    <= 1'b0;
      end else begin
         if (wr) begin
            sh_prd <= wr_prd;
            sh_dty <= wr_dty;
            pend   <= 1'b1;
         end else if (load) begin
            pend   <= 1'b0;
         end
         if (load) begin
            cur_prd <= sh_prd;
            cur_dty <= sh_dty;
         end
         if (!run || wrap)
            cnt <= '0;
         else if (tick)
            cnt <= cnt + 1'b1;
      end
   end

   assign pwm_o    = (run && (cnt < cur_dty)) ? act_hi : !act_hi;
   assign busy_o   = pend;
   assign shadow_o = {sh_prd, sh_dty};

   // R3: the cycle counter never passes the period field
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= cur_prd);

   // R7: running values change only after an update was waiting
   a_r7_load_src: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({cur_prd, cur_dty}) |-> $past(pend));

   // R7: the ready flag rises only after a write
   a_r7_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(wr));

   // R6: a stopped channel restarts its cycle counter
   a_r6_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);

   // R8: zero duty keeps the output inactive
   a_r8_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (cur_dty == '0)) |-> (pwm_o == !act_hi));

endmodule

// File: rtl/pwm_dual_ctrl.sv
`timescale 1ns/1ps
module pwm_dual_ctrl #(
   parameter int unsigned NCH       = 2,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned CH_STRIDE = 15,
   parameter int unsigned RDY_LSB   = 28,
   parameter bit          PASS_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NCH-1:0]    pwm_out
);
   import pwm_dual_pkg::*;

   localparam int unsigned IDX_W = ADDR_W - 2;

   generate
      if (CFG_W + CH_STRIDE * (NCH - 1) > RDY_LSB) begin : g_bad_stride
         $error("channel groups overlap the ready flags");
      end
      if (RDY_LSB + NCH > DATA_W) begin : g_bad_rdy
         $error("ready flags do not fit in the data word");
      end
      if (2 * CNT_W > DATA_W) begin : g_bad_cnt
         $error("period and duty fields do not fit in the data word");
      end
      if ((NCH + 1) > (1 << IDX_W)) begin : g_bad_addr
         $error("address space too small for all channel words");
      end
   endgenerate

   logic [IDX_W-1:0]   widx;
   chan_cfg_t          cfg_q  [NCH];
   logic [2*CNT_W-1:0] shadow [NCH];
   logic [NCH-1:0]     busy;
   logic               unused_bits;

   assign widx        = reg_addr[ADDR_W-1:2];
   assign unused_bits = ^{reg_addr[1:0], reg_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) cfg_q[c] <= '0;
      end else if (reg_wr && (widx == '0)) begin
         for (int c = 0; c < NCH; c++)
            cfg_q[c] <= chan_cfg_t'(reg_wdata[c*CH_STRIDE +: CFG_W]);
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (widx == '0) begin
         for (int c = 0; c < NCH; c++) begin
            reg_rdata[c*CH_STRIDE +: CFG_W] = cfg_q[c];
            reg_rdata[RDY_LSB + c]          = busy[c];
         end
      end else begin
         for (int c = 0; c < NCH; c++)
            if (widx == IDX_W'(c + 1)) reg_rdata = DATA_W'(shadow[c]);
      end
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic run;
         logic tick;
         assign run = cfg_q[c].en && cfg_q[c].gate;

         pwm_tick_gen #(.DIV_W(DIV_W), .PASS_EN(PASS_EN)) u_tick (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run),
            .code (cfg_q[c].code),
            .tick (tick)
         );

         pwm_chan_core #(.CNT_W(CNT_W)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .tick    (tick),
            .act_hi  (cfg_q[c].act_hi),
            .wr      (reg_wr && (widx == IDX_W'(c + 1))),
            .wr_prd  (reg_wdata[2*CNT_W-1:CNT_W]),
            .wr_dty  (reg_wdata[CNT_W-1:0]),
            .pwm_o   (pwm_out[c]),
            .busy_o  (busy[c]),
            .shadow_o(shadow[c])
         );

         // R6: a channel that is not both enabled and gated sits at the idle level
         a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            !run |-> (pwm_out[c] == !cfg_q[c].act_hi));
      end
   endgenerate

endmodule

// File: tb/pwm_dual_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_dual_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  pwm_out;

   pwm_dual_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;

   typedef struct {
      int    at;
      int    kind;   // 0: output pin, 1: ready flag in control word
      int    ch;
      logic  val;
      string tag;
   } exp_t;
   exp_t sb[$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push(input int at, input int kind, input int ch, input logic v, input string tag);
      exp_t e;
      e.at = at; e.kind = kind; e.ch = ch; e.val = v; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compares every queued item in the cycle it belongs to
   always @(negedge clk) begin : mon
      exp_t rest[$];
      logic got;
      rest = {};
      foreach (sb[i]) begin
         if (sb[i].at == cyc) begin
            got = (sb[i].kind == 0) ? pwm_out[sb[i].ch] : reg_rdata[28 + sb[i].ch];
            check(sb[i].tag, {31'd0, got}, {31'd0, sb[i].val});
         end else if (sb[i].at < cyc) begin
            checks++;
            errors++;
            $display("FAIL %s actual=missed expected=%0b (cycle %0d)", sb[i].tag, sb[i].val, sb[i].at);
         end else begin
            rest.push_back(sb[i]);
         end
      end
      sb = rest;
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d, output int at);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_addr = '0;
      at = cyc;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
      @(posedge clk); #1;
      reg_addr = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin : main
      int c, c4, w, x;
      logic [31:0] d;

      // R1: reset state
      idle(2);
      @(negedge clk);
      check("R1 control word after reset", reg_rdata, 32'h0);
      check("R1 outputs idle high after reset", {30'd0, pwm_out}, 32'h3);
      @(posedge clk); #1 rst_n = 1'b1;
      rd(4'h4, d);
      check("R1 period word 0 after reset", d, 32'h0);

      // R7 stopped channel: ready set on write, cleared next clock
      wr(4'h4, 32'h0003_0002, c);
      push(c,     1, 0, 1'b1, "R7 ready set by write");
      push(c + 1, 1, 0, 1'b0, "R7 stopped channel loads next clock");

      // R3/R5: code 15, period 4, duty 2, active high
      wr(4'h0, 32'h0000_007F, c);
      for (int k = 0; k < 12; k++)
         push(c + k, 0, 0, (k % 4) < 2, "R3 R5 period 4 duty 2 active high");
      idle(14);

      // R7 running channel: update waits for cycle end
      wr(4'h4, 32'h0001_0001, w);
      x = w + 1;
      while (((x - c) % 4) != 0) x++;
      for (int n = w; n < x; n++)
         push(n, 0, 0, ((n - c) % 4) < 2, "R7 old setting holds until cycle end");
      push(w,     1, 0, 1'b1, "R7 ready set while update waits");
      push(x - 1, 1, 0, 1'b1, "R7 ready still set before cycle end");
      push(x,     1, 0, 1'b0, "R7 ready clears at cycle end");
      for (int j = 0; j < 8; j++)
         push(x + j, 0, 0, (j % 2) == 0, "R7 new period 2 duty 1 after cycle end");
      idle(14);

      // R6: gate clear, restart, enable clear
      wr(4'h0, 32'h0000_003F, c);
      for (int k = 0; k < 5; k++) push(c + k, 0, 0, 1'b0, "R6 gate clear holds inactive");
      idle(6);
      wr(4'h0, 32'h0000_007F, c);
      for (int k = 0; k < 6; k++) push(c + k, 0, 0, (k % 2) == 0, "R6 restart begins at tick 0");
      idle(7);
      wr(4'h0, 32'h0000_006F, c);
      for (int k = 0; k < 4; k++) push(c + k, 0, 0, 1'b0, "R6 enable clear holds inactive");
      idle(5);

      // R5: active state 0 inverts
      wr(4'h0, 32'h0000_005F, c4);
      for (int k = 0; k < 6; k++) push(c4 + k, 0, 0, (k % 2) != 0, "R5 active low inverts output");
      idle(7);

      // R8/R9: channel 1 zero duty then duty above period; channel 0 keeps running
      wr(4'h8, 32'h0002_0000, c);
      wr(4'h0, 32'h002F_805F, c);
      for (int k = 0; k < 6; k++) begin
         push(c + k, 0, 1, 1'b1, "R8 zero duty stays inactive");
         push(c + k, 0, 0, ((c + k - c4) % 2) != 0, "R9 channel 0 undisturbed");
      end
      idle(7);
      wr(4'h8, 32'h0002_0005, w);
      push(w, 1, 1, 1'b1, "R7 channel 1 ready set by write");
      for (int n = w + 4; n < w + 10; n++) begin
         push(n, 0, 1, 1'b0, "R8 duty above period stays active");
         push(n, 0, 0, ((n - c4) % 2) != 0, "R9 channel 0 undisturbed");
      end
      idle(12);

      // R2: readback masks, read-only flags, stored-only bits
      wr(4'h0, 32'hFFFF_FFFF, c);
      for (int k = 0; k < 6; k++)
         push(c + k, 0, 0, ((c + k - c4) % 2) == 0, "R2 mode pulse bypass bits do not alter output");
      rd(4'h0, d);
      check("R2 control readback mask", d, 32'h01FF_83FF);
      rd(4'h4, d);
      check("R2 channel 0 word readback", d, 32'h0001_0001);
      rd(4'h8, d);
      check("R2 channel 1 word readback", d, 32'h0002_0005);
      rd(4'hC, d);
      check("R2 unmapped address reads 0", d, 32'h0);
      idle(4);

      // R4: divide by 120 on channel 1
      wr(4'h0, 32'h0, c);
      wr(4'h8, 32'h0001_0001, c);
      wr(4'h0, 32'h0038_0000, c);
      push(c, 0, 0, 1'b1, "R6 disabled channel 0 idles high");
      push(c,       0, 1, 1'b1, "R4 div 120 start active");
      push(c + 119, 0, 1, 1'b1, "R4 div 120 last active clock");
      push(c + 120, 0, 1, 1'b0, "R4 div 120 first inactive clock");
      push(c + 239, 0, 1, 1'b0, "R4 div 120 last inactive clock");
      push(c + 240, 0, 1, 1'b1, "R4 div 120 next cycle");
      idle(245);

      // R4: divide by 480
      wr(4'h0, 32'h0, c);
      wr(4'h0, 32'h003A_0000, c);
      push(c + 479, 0, 1, 1'b1, "R4 div 480 last active clock");
      push(c + 480, 0, 1, 1'b0, "R4 div 480 first inactive clock");
      push(c + 959, 0, 1, 1'b0, "R4 div 480 last inactive clock");
      push(c + 960, 0, 1, 1'b1, "R4 div 480 next cycle");
      idle(965);

      // R4: divide by 12000 (second bank)
      wr(4'h0, 32'h0, c);
      wr(4'h0, 32'h003C_0000, c);
      push(c + 11999, 0, 1, 1'b1, "R4 div 12000 last active clock");
      push(c + 12000, 0, 1, 1'b0, "R4 div 12000 first inactive clock");
      idle(12005);

      // R4: unused code 5 stalls the counter at tick 0
      wr(4'h0, 32'h0, c);
      wr(4'h0, 32'h003A_8000, c);
      push(c,       0, 1, 1'b1, "R4 unused code stalls");
      push(c + 100, 0, 1, 1'b1, "R4 unused code stalls");
      push(c + 300, 0, 1, 1'b1, "R4 unused code stalls");
      idle(305);

      while (sb.size() != 0) @(posedge clk);
      @(posedge clk);
      finish_run();
   end

endmodule